// File: doc/BRIEF.md
# Cascadable Interrupt Request Front-End

This block is the input stage of a five-source interrupt controller. Each source pin is asynchronous. It passes through a two-flop synchronizer and then through a per-source detector, which runs in edge mode or level mode. The detector output is gated by a per-source mask. A fixed-priority encoder then picks a winner, and the block raises `cpu_req_o` toward the processor core.

When the core acknowledges, the block answers with a one-cycle vector. For an internally typed source the vector is `VEC_BASE` plus the source index. Sources 0 and 1 can instead be put in cascade mode. In that mode a companion pin turns into an acknowledge strobe, and the interrupt type is taken from an external peripheral. Pin 2 is the companion for source 0 and pin 3 is the companion for source 1.

In slave mode, pin 3 turns into a request output toward an external master controller. The block is configured through a simple write port. A pin that has become an output is ignored as an input.

Top module: `irq_front`

## Requirements
- R1: After reset, `cpu_req_o`, `vec_valid_o`, `pin2_o`, `pin3_o` and `pin_oe_o` are 0. All five sources are masked, in edge mode, and not cascaded. Slave mode is off.
- R2: Configuration uses `cfg_addr_i` 0 to 4, one address per source. The fields are: bit 0 masks the source when 1, bit 1 selects level mode when 1, and bit 2 selects cascade mode (sources 0 and 1 only). In edge mode, an unmasked rising edge on `req_i[k]` makes `cpu_req_o` high in the cycle after the third rising clock edge following the input change. The request then stays high until it is acknowledged, even if the input falls.
- R3: In level mode, `cpu_req_o` goes high after the second clock edge and follows the synchronized input. A level request that drops before the acknowledge is lost: a later `cpu_ack_i` yields no vector.
- R4: A masked source never raises `cpu_req_o` and never yields a vector. An edge seen while masked is not remembered.
- R5: When `cpu_ack_i` is sampled high while `cpu_req_o` is high, the lowest-numbered active source wins. For a non-cascaded winner, `vec_valid_o` is high for exactly the cycle after that edge, with `vec_o` = 8 + source index.
- R6: The acknowledge clears only the winner's edge-pending state. Other pending sources keep requesting afterwards.
- R7: When source 0 is in cascade mode, `pin_oe_o[0]` is 1 and `req_i[2]` is ignored. On acknowledge of source 0, `pin2_o` is high for exactly the one cycle after the acknowledge edge. `ext_type_i` is sampled one cycle later, and it is presented on `vec_o` with `vec_valid_o` in the cycle after that sampling edge.
- R8: When source 1 is in cascade mode, `pin_oe_o[1]` is 1, `req_i[3]` is ignored, and `pin3_o` gives the same strobe for source 1 with the same timing as R7.
- R9: Slave mode is set by bit 0 at `cfg_addr_i` 5. In slave mode, `pin_oe_o[1]` is 1 and `req_i[3]` is ignored. Unless source 1 is cascaded, `pin3_o` equals `cpu_req_o`.
- R10: From the acknowledge edge until `vec_valid_o` falls, `cpu_req_o` is 0. An acknowledge with no active source is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Asynchronous request pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration address |
| cfg_wdata_i | input | 3 | Configuration write data |
| cpu_req_o | output | 1 | Interrupt request to the core |
| cpu_ack_i | input | 1 | Acknowledge from the core |
| vec_o | output | 8 | Interrupt type |
| vec_valid_o | output | 1 | `vec_o` is valid for this cycle |
| ext_type_i | input | 8 | Type supplied by a cascaded peripheral |
| pin2_o | output | 1 | Pin 2 output value (acknowledge strobe for source 0) |
| pin3_o | output | 1 | Pin 3 output value (strobe for source 1, or request to master) |
| pin_oe_o | output | 2 | Output enables for pins 2 and 3 |

## Verification
Each result has a fixed latency, counted in clock edges:
- An edge request reaches `cpu_req_o` three edges after the input change, and a level request reaches it two edges after.
- A vector appears one edge after the acknowledge for an internally typed source, and three edges after for a cascaded source.
- A strobe occupies the single cycle between those two cases.

The bench drives every input on the falling clock edge and samples on the falling edge. It therefore checks the request exactly one cycle before and at the cycle it is due. A driver task queues each expected vector just before it raises the acknowledge. A monitor compares every `vec_valid_o` cycle against the queue, so a vector that is early, late, missing or unwanted is reported.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } ack_st_e;

  typedef struct packed {
    logic cascade;
    logic level;
    logic mask;
  } src_cfg_t;

  localparam int CFG_W = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] dis_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] act_o
);
  logic [N-1:0] eff;
  assign eff = sync_i & ~dis_i;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic dly_q, pend_q, rise;
    assign rise = eff[g] & ~dly_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        dly_q <= eff[g];
        if (dis_i[g] || level_i[g] || mask_i[g]) pend_q <= 1'b0;
        else if (rise)                          pend_q <= 1'b1;
        else if (clr_i[g])                      pend_q <= 1'b0;
      end
    end

    assign act_o[g] = ~mask_i[g] & (level_i[g] ? eff[g] : pend_q);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (act_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |act_i;
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
#(
  parameter int N        = 5,
  parameter int IDX_W    = $clog2(N),
  parameter int TYPE_W   = 8,
  parameter int VEC_BASE = 8,
  parameter int N_CASC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              casc_i,
  input  logic              ack_i,
  input  logic [TYPE_W-1:0] ext_type_i,
  output logic [N-1:0]      clr_o,
  output logic [N_CASC-1:0] strobe_o,
  output logic              idle_o,
  output logic [TYPE_W-1:0] vec_o,
  output logic              vec_valid_o
);
  ack_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign take = ack_i & any_i & (st_q == ST_IDLE);

  always_comb begin
    clr_o = '0;
    if (take) clr_o[idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      vec_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (take) begin
          idx_q <= idx_i;
          if (casc_i) st_q <= ST_STROBE;
          else begin
            vec_o <= TYPE_W'(VEC_BASE) + TYPE_W'(idx_i);
            st_q  <= ST_DONE;
          end
        end
        ST_STROBE: st_q <= ST_WAIT;
        ST_WAIT: begin
          vec_o <= ext_type_i;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < N_CASC; c++) begin : g_strobe
    assign strobe_o[c] = (st_q == ST_STROBE) && (idx_q == IDX_W'(c));
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign vec_valid_o = (st_q == ST_DONE);
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int N_SRC    = 5,
  parameter int TYPE_W   = 8,
  parameter int VEC_BASE = 8,
  parameter int SYNC_N   = 2,
  parameter int ADDR_W   = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              cpu_req_o,
  input  logic              cpu_ack_i,
  output logic [TYPE_W-1:0] vec_o,
  output logic              vec_valid_o,
  input  logic [TYPE_W-1:0] ext_type_i,
  output logic              pin2_o,
  output logic              pin3_o,
  output logic [1:0]        pin_oe_o
);
  localparam int IDX_W     = $clog2(N_SRC);
  localparam int N_CASC    = 2;
  localparam int SLAVE_ADR = N_SRC;

  src_cfg_t [N_SRC-1:0] cfg_q;
  logic                 slave_q;
  logic [N_SRC-1:0]     mask, level, dis, sync, act, clr;
  logic [N_CASC-1:0]    casc, strobe;
  logic                 any, idle, win_casc;
  logic [IDX_W-1:0]     idx;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= '{cascade: 1'b0, level: 1'b0, mask: 1'b1};
      end else if (cfg_we_i && cfg_addr_i == ADDR_W'(g)) begin
        cfg_q[g].mask    <= cfg_wdata_i[0];
        cfg_q[g].level   <= cfg_wdata_i[1];
        cfg_q[g].cascade <= (g < N_CASC) ? cfg_wdata_i[2] : 1'b0;
      end
    end
    assign mask[g]  = cfg_q[g].mask;
    assign level[g] = cfg_q[g].level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slave_q <= 1'b0;
    else if (cfg_we_i && cfg_addr_i == ADDR_W'(SLAVE_ADR)) slave_q <= cfg_wdata_i[0];
  end

  assign casc[0] = cfg_q[0].cascade;
  assign casc[1] = cfg_q[1].cascade;

  // pins turned into outputs never feed detection
  always_comb begin
    dis    = '0;
    dis[2] = casc[0];
    dis[3] = casc[1] | slave_q;
  end

  irq_sync #(.W(N_SRC), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(sync)
  );

  irq_detect #(.N(N_SRC)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .dis_i(dis),
    .mask_i(mask), .level_i(level), .clr_i(clr), .act_o(act)
  );

  irq_prio #(.N(N_SRC)) u_prio (
    .act_i(act), .any_o(any), .idx_o(idx)
  );

  assign win_casc = (idx < IDX_W'(N_CASC)) && casc[idx[0]];

  irq_ack_fsm #(
    .N(N_SRC), .TYPE_W(TYPE_W), .VEC_BASE(VEC_BASE), .N_CASC(N_CASC)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_i(any), .idx_i(idx),
    .casc_i(win_casc), .ack_i(cpu_ack_i), .ext_type_i(ext_type_i),
    .clr_o(clr), .strobe_o(strobe), .idle_o(idle),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  assign cpu_req_o = any & idle;
  assign pin2_o    = strobe[0];
  assign pin3_o    = casc[1] ? strobe[1] : (slave_q & cpu_req_o);
  assign pin_oe_o  = {casc[1] | slave_q, casc[0]};
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_req_o,
  input logic       cpu_ack_i,
  input logic       vec_valid_o,
  input logic       pin2_o,
  input logic       pin3_o,
  input logic [1:0] pin_oe_o
);
  assert_vec_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  assert_no_req_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ack_i && cpu_req_o) |=> !cpu_req_o);

  assert_no_req_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !cpu_req_o);

  assert_strobe0_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin2_o |=> !pin2_o);

  assert_strobe0_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin2_o |-> pin_oe_o[0]);

  assert_pin3_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin3_o |-> pin_oe_o[1]);

  assert_pins_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pin2_o, pin3_o}));
endmodule

bind irq_front irq_front_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_o(cpu_req_o), .cpu_ack_i(cpu_ack_i),
  .vec_valid_o(vec_valid_o), .pin2_o(pin2_o), .pin3_o(pin3_o), .pin_oe_o(pin_oe_o)
);

// File: tb/sim_irq_front.sv
`timescale 1ns/1ps
module sim_irq_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req = '0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [2:0] wdata = '0;
  logic       ack = 1'b0;
  logic [7:0] ext = '0;
  logic       cpu_req, vec_valid, p2, p3;
  logic [7:0] vec;
  logic [1:0] oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  irq_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cpu_req_o(cpu_req), .cpu_ack_i(ack), .vec_o(vec),
    .vec_valid_o(vec_valid), .ext_type_i(ext), .pin2_o(p2), .pin3_o(p3), .pin_oe_o(oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [2:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic do_ack(input bit expect_vec, input logic [7:0] v);
    @(negedge clk);
    if (expect_vec) exp_q.push_back(v);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every valid vector must match the queue head
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R3/R10 unexpected vector actual=%0h expected=none", vec);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec !== e) begin
          errors++;
          $display("FAIL R5/R7 vector actual=%0h expected=%0h", vec, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 cpu_req", cpu_req, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 oe", oe, 0);
    chk("R1 pins", {p2, p3}, 0);

    // R4: masked source (all masked after reset)
    req[0] = 1'b1;
    idle(5);
    chk("R4 masked req", cpu_req, 0);
    do_ack(0, 0);
    idle(2);
    chk("R10 ack ignored", cpu_req, 0);
    req[0] = 1'b0;

    // R2: edge mode on source 4
    wr(3'd4, 3'b000);
    idle(3);
    req[4] = 1'b1;
    idle(2);
    chk("R2 edge latency-1", cpu_req, 0);
    idle(1);
    chk("R2 edge latency", cpu_req, 1);
    req[4] = 1'b0;
    idle(5);
    chk("R2 held after drop", cpu_req, 1);
    do_ack(1, 8'd12);
    chk("R10 req low in vec cycle", cpu_req, 0);
    idle(2);
    chk("R6 cleared after ack", cpu_req, 0);

    // R5/R6: priority between sources 1 and 3
    wr(3'd1, 3'b000);
    wr(3'd3, 3'b000);
    idle(2);
    req[1] = 1'b1; req[3] = 1'b1;
    idle(4);
    chk("R5 both pending", cpu_req, 1);
    do_ack(1, 8'd9);
    idle(2);
    chk("R6 other still pending", cpu_req, 1);
    do_ack(1, 8'd11);
    idle(2);
    chk("R6 all cleared", cpu_req, 0);
    req[1] = 1'b0; req[3] = 1'b0;
    wr(3'd1, 3'b001);
    wr(3'd3, 3'b001);

    // R3: level mode on source 2
    wr(3'd2, 3'b010);
    idle(2);
    req[2] = 1'b1;
    idle(1);
    chk("R3 level latency-1", cpu_req, 0);
    idle(1);
    chk("R3 level latency", cpu_req, 1);
    do_ack(1, 8'd10);
    idle(2);
    chk("R3 level still high", cpu_req, 1);
    req[2] = 1'b0;
    idle(3);
    chk("R3 level follows drop", cpu_req, 0);
    req[2] = 1'b1;
    idle(4);
    req[2] = 1'b0;
    idle(4);
    do_ack(0, 0);
    idle(3);
    chk("R3 lost request", cpu_req, 0);

    // R7: cascade on source 0, pin 2 becomes strobe
    wr(3'd0, 3'b100);
    idle(1);
    chk("R7 oe0", oe, 2'b01);
    req[2] = 1'b1;
    idle(5);
    chk("R7 pin2 input ignored", cpu_req, 0);
    req[0] = 1'b1;
    idle(3);
    chk("R7 req src0", cpu_req, 1);
    ext = 8'hA5;
    exp_q.push_back(8'hA5);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R7 strobe high", p2, 1);
    chk("R7 no vec yet", vec_valid, 0);
    @(negedge clk);
    chk("R7 strobe low", p2, 0);
    @(negedge clk);
    chk("R7 vec valid", vec_valid, 1);
    ext = 8'h00;
    req[0] = 1'b0; req[2] = 1'b0;
    idle(3);
    wr(3'd0, 3'b001);
    wr(3'd2, 3'b001);

    // R8: cascade on source 1, with slave also set
    wr(3'd1, 3'b100);
    wr(3'd5, 3'b001);
    wr(3'd3, 3'b000);
    idle(1);
    chk("R8 oe1", oe, 2'b10);
    req[3] = 1'b1;
    idle(5);
    chk("R8 pin3 input ignored", cpu_req, 0);
    req[1] = 1'b1;
    idle(3);
    chk("R8 pin3 not irq in cascade", p3, 0);
    ext = 8'h3C;
    exp_q.push_back(8'h3C);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R8 strobe high", p3, 1);
    @(negedge clk);
    chk("R8 strobe low", p3, 0);
    @(negedge clk);
    chk("R8 vec valid", vec_valid, 1);
    req[1] = 1'b0;
    idle(3);

    // R9: slave only, pin 3 forwards request
    wr(3'd1, 3'b001);
    idle(4);
    chk("R9 oe slave", oe, 2'b10);
    chk("R9 pin3 idle", p3, 0);
    req[4] = 1'b1;
    idle(3);
    chk("R9 pin3 forwards", p3, 1);
    do_ack(1, 8'd12);
    chk("R9 pin3 drops", p3, 0);
    req[4] = 1'b0; req[3] = 1'b0;
    idle(4);

    chk("R5 queue drained", 8'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule